// File: doc/BRIEF.md
# Eight-Point Forward DCT Butterfly Pipeline

This block computes an eight-point forward discrete cosine transform on one vector of eight signed 16-bit samples per clock. It does not use a matrix multiply. It uses a fixed butterfly factorisation:

- Mirrored sums and differences split the vector into an even half and an odd half.
- The even half passes through a four-point sub-transform.
- The odd half first takes a cosine-scaled pre-rotation and then a pair of rotations.

Every multiply uses a 14-bit fixed-point cosine constant. Each multiply result is narrowed back to 16 bits with a rounding right shift. Additions between stages wrap at 16 bits, and nothing saturates.

Samples arrive packed in one bus together with a valid strobe. Coefficients leave in natural frequency order three clock cycles later, together with their own valid strobe. A two-dimensional transform is built by running rows and then columns through this block. The surrounding logic does the transposition, any input pre-scaling and any final scaling.

Top module: `fdct8_core`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every bit of `out_coef` are cleared to 0.
- R2: `out_valid` is high exactly three clock edges after the edge that sampled `in_valid` high. One vector can be accepted on every cycle, back to back.
- R3: The first butterfly forms sums x[i]+x[7-i] and differences x[i]-x[7-i] for i=0..3. The even sums e0=s0+s3, e1=s1+s2, e2=s1-s2 and e3=s0-s3 follow, and every one of these wraps modulo 2^16.
- R4: Coefficient 0 is round((e0+e1)*11585) and coefficient 4 is round((e0-e1)*11585). The sum and the difference are formed at 32 bits before the multiply.
- R5: Coefficient 2 is round(e2*6270 + e3*15137) and coefficient 6 is round(e3*6270 - e2*15137). A vector whose eight samples are all equal gives 0 on coefficients 2 and 6.
- R6: The odd half forms a=round((s6-s5)*11585) and b=round((s6+s5)*11585), where s6-s5 and s6+s5 wrap at 16 bits. It then forms p0=s4+a, p1=s4-a, p2=s7-b and p3=s7+b, each wrapping at 16 bits. Here s4=x3-x4, s5=x2-x5, s6=x1-x6 and s7=x0-x7.
- R7: The odd coefficients are formed as follows, and a vector of equal samples gives 0 on all four:
  - coefficient 1 is round(p3*16069 + p0*3196)
  - coefficient 7 is round(p3*3196 - p0*16069)
  - coefficient 5 is round(p1*13623 + p2*9102)
  - coefficient 3 is round(p2*13623 - p1*9102)
- R8: round(v) adds 8192 to the 32-bit signed value v, shifts it arithmetically right by 14 and keeps the low 16 bits.
- R9: While `out_valid` is low, `out_coef` holds its last value, whatever `in_samp` does during cycles with `in_valid` low.
- R10: Sample i sits in `in_samp[16*i+15:16*i]` and coefficient k in `out_coef[16*k+15:16*k]`, both two's complement. An all-zero input vector yields an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_samp` on this cycle |
| in_samp | input | 128 | Eight signed 16-bit samples, lane i at bits 16*i+15:16*i |
| out_valid | output | 1 | Qualifies `out_coef`, three cycles after `in_valid` |
| out_coef | output | 128 | Eight signed 16-bit coefficients in frequency order |

## Verification
The latency and hold properties assume `in_valid` is a clean 0/1 level after reset. The bench drives it only from the falling edge, so the property sees it settled. The zero-input and equal-sample properties assume that the three earlier input vectors seen by the checker are the vectors that reach the output. That holds because every valid vector is kept in the pipeline and never dropped.

The data properties rely on the 32-bit accumulations not overflowing. For any 16-bit operand the largest magnitude is below 2^30, so no input value leaves that range. The bench therefore covers full-scale vectors, random vectors and junk on idle cycles without restriction.

// File: rtl/fdct8_pkg.sv
package fdct8_pkg;

    // Geometry and arithmetic precision
    localparam int NPT  = 8;             // points per transform
    localparam int SW   = 16;            // sample / coefficient width
    localparam int ACCW = 32;            // product and accumulator width
    localparam int PREC = 14;            // fractional bits of the cosine constants
    localparam int VW   = NPT * SW;      // packed vector width
    localparam int LAT  = 3;             // pipeline depth in cycles

    typedef logic signed [SW-1:0]   smp_t;
    typedef logic signed [ACCW-1:0] acc_t;

    // Rounding offset: half of one output LSB
    localparam acc_t HALF = acc_t'(1) <<< (PREC - 1);

    // Cosine constants, round(2^PREC * cos(k*pi/64))
    localparam acc_t COS4  = 32'sd16069;
    localparam acc_t COS8  = 32'sd15137;
    localparam acc_t COS12 = 32'sd13623;
    localparam acc_t COS16 = 32'sd11585;
    localparam acc_t COS20 = 32'sd9102;
    localparam acc_t COS24 = 32'sd6270;
    localparam acc_t COS28 = 32'sd3196;

    // State after the input butterfly: the even sub-transform inputs and the odd differences
    typedef struct packed {
        smp_t e0;
        smp_t e1;
        smp_t e2;
        smp_t e3;
        smp_t d4;
        smp_t d5;
        smp_t d6;
        smp_t d7;
    } front_t;

    // State after the even outputs and the odd pre-rotation
    typedef struct packed {
        smp_t y0;
        smp_t y2;
        smp_t y4;
        smp_t y6;
        smp_t d4;
        smp_t d7;
        smp_t ra;
        smp_t rb;
    } mid_t;

    // Sign-extend a sample to accumulator width
    function automatic acc_t widen(smp_t v);
        return acc_t'(v);
    endfunction

    // Round to nearest at PREC fractional bits, then keep the low SW bits
    function automatic smp_t narrow(acc_t v);
        acc_t t;
        t = (v + HALF) >>> PREC;
        return t[SW-1:0];
    endfunction

    // Two-term multiply-accumulate (a*ka +/- b*kb), rounded to SW bits
    function automatic smp_t rot(smp_t a, acc_t ka, smp_t b, acc_t kb, logic neg);
        acc_t m;
        acc_t n;
        m = widen(a) * ka;
        n = widen(b) * kb;
        return narrow(neg ? (m - n) : (m + n));
    endfunction

endpackage

// File: rtl/fdct8_front.sv
module fdct8_front
    import fdct8_pkg::*;
(
    input  logic [VW-1:0] samp,
    output front_t        fr
);
    smp_t x [NPT];
    smp_t s [NPT];

    // Split the packed bus into lanes
    for (genvar i = 0; i < NPT; i++) begin : g_lane
        assign x[i] = samp[i*SW +: SW];
    end

    // Mirrored butterfly: sums into the lower half, differences into the upper half
    for (genvar i = 0; i < NPT/2; i++) begin : g_bfly
        assign s[i]         = x[i] + x[NPT-1-i];
        assign s[NPT-1-i]   = x[i] - x[NPT-1-i];
    end

    // Second butterfly on the even half; odd differences pass through
    always_comb begin
        fr.e0 = s[0] + s[3];
        fr.e1 = s[1] + s[2];
        fr.e2 = s[1] - s[2];
        fr.e3 = s[0] - s[3];
        fr.d4 = s[4];
        fr.d5 = s[5];
        fr.d6 = s[6];
        fr.d7 = s[7];
    end
endmodule

// File: rtl/fdct8_mid.sv
module fdct8_mid
    import fdct8_pkg::*;
(
    input  front_t fr,
    output mid_t   md
);
    acc_t sum01;
    acc_t dif01;
    smp_t odd_dif;
    smp_t odd_sum;

    always_comb begin
        // Even half: DC/Nyquist pair at full accumulator width
        sum01   = widen(fr.e0) + widen(fr.e1);
        dif01   = widen(fr.e0) - widen(fr.e1);
        md.y0   = narrow(sum01 * COS16);
        md.y4   = narrow(dif01 * COS16);
        // Even half: quarter-frequency rotation
        md.y2   = rot(fr.e2, COS24, fr.e3, COS8, 1'b0);
        md.y6   = rot(fr.e3, COS24, fr.e2, COS8, 1'b1);
        // Odd half: pre-rotation of the inner pair, wrapped at sample width
        odd_dif = fr.d6 - fr.d5;
        odd_sum = fr.d6 + fr.d5;
        md.ra   = narrow(widen(odd_dif) * COS16);
        md.rb   = narrow(widen(odd_sum) * COS16);
        md.d4   = fr.d4;
        md.d7   = fr.d7;
    end
endmodule

// File: rtl/fdct8_back.sv
module fdct8_back
    import fdct8_pkg::*;
(
    input  mid_t          md,
    output logic [VW-1:0] coef
);
    smp_t p0;
    smp_t p1;
    smp_t p2;
    smp_t p3;
    smp_t y [NPT];

    always_comb begin
        // Combine outer differences with the pre-rotated inner pair
        p0   = md.d4 + md.ra;
        p1   = md.d4 - md.ra;
        p2   = md.d7 - md.rb;
        p3   = md.d7 + md.rb;
        // Even coefficients arrive finished
        y[0] = md.y0;
        y[2] = md.y2;
        y[4] = md.y4;
        y[6] = md.y6;
        // Odd rotations
        y[1] = rot(p3, COS4,  p0, COS28, 1'b0);
        y[7] = rot(p3, COS28, p0, COS4,  1'b1);
        y[5] = rot(p1, COS12, p2, COS20, 1'b0);
        y[3] = rot(p2, COS12, p1, COS20, 1'b1);
    end

    // Pack in natural frequency order
    for (genvar k = 0; k < NPT; k++) begin : g_pack
        assign coef[k*SW +: SW] = y[k];
    end
endmodule

// File: rtl/fdct8_core.sv
module fdct8_core
    import fdct8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [VW-1:0] in_samp,
    output logic          out_valid,
    output logic [VW-1:0] out_coef
);
    front_t          front_c;
    front_t          front_q;
    mid_t            mid_c;
    mid_t            mid_q;
    logic [VW-1:0]   coef_c;
    logic [VW-1:0]   coef_q;
    logic [LAT-1:0]  vpipe;

    fdct8_front u_front (.samp(in_samp), .fr(front_c));
    fdct8_mid   u_mid   (.fr(front_q),   .md(mid_c));
    fdct8_back  u_back  (.md(mid_q),     .coef(coef_c));

    // Each stage loads only when its valid bit is set, so idle cycles leave data untouched
    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe   <= '0;
            front_q <= '0;
            mid_q   <= '0;
            coef_q  <= '0;
        end else begin
            vpipe <= {vpipe[LAT-2:0], in_valid};
            if (in_valid) front_q <= front_c;
            if (vpipe[0]) mid_q   <= mid_c;
            if (vpipe[1]) coef_q  <= coef_c;
        end
    end

    assign out_valid = vpipe[LAT-1];
    assign out_coef  = coef_q;
endmodule

// File: rtl/fdct8_core_chk.sv
module fdct8_core_chk
    import fdct8_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [VW-1:0] in_samp,
    input logic          out_valid,
    input logic [VW-1:0] out_coef
);
    logic [2:0] cnt;
    logic       flat;

    // Cycles since reset, saturating
    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (cnt != 3'd7) cnt <= cnt + 3'd1;
    end

    always_comb begin
        flat = 1'b1;
        for (int i = 1; i < NPT; i++)
            if (in_samp[i*SW +: SW] != in_samp[0 +: SW]) flat = 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == 3'd0) |-> (!out_valid && out_coef == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd3) |-> (out_valid == $past(in_valid, 3)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd1 && !out_valid) |-> $stable(out_coef));

    // R10
    zero_in_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd3 && out_valid && $past(in_samp, 3) == '0) |-> (out_coef == '0));

    // R5
    flat_even_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd3 && out_valid && $past(flat, 3))
        |-> (out_coef[2*SW +: SW] == '0 && out_coef[6*SW +: SW] == '0));

    // R7
    flat_odd_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt >= 3'd3 && out_valid && $past(flat, 3))
        |-> (out_coef[1*SW +: SW] == '0 && out_coef[3*SW +: SW] == '0 &&
             out_coef[5*SW +: SW] == '0 && out_coef[7*SW +: SW] == '0));

    // R2
    valid_known_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(out_valid));
endmodule

bind fdct8_core fdct8_core_chk u_chk (.*);

// File: tb/fdct8_core_tb.sv
module fdct8_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_samp = '0;
    logic         out_valid;
    logic [127:0] out_coef;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    int           qc [$];
    logic [127:0] qv [$];
    string        qt [$];
    logic [127:0] last_out = '0;

    fdct8_core u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_samp(in_samp),
        .out_valid(out_valid), .out_coef(out_coef)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model built from the requirements ----------------
    function automatic logic signed [15:0] rnd(int v);
        int t;
        t = (v + 8192) >>> 14;
        return t[15:0];
    endfunction

    function automatic logic [127:0] ref_dct(logic [127:0] xin);
        logic signed [15:0] x [8];
        logic signed [15:0] s [8];
        logic signed [15:0] e0, e1, e2, e3, dd, ss, a, b, p0, p1, p2, p3;
        logic signed [15:0] y [8];
        logic [127:0] r;
        for (int i = 0; i < 8; i++) x[i] = xin[16*i +: 16];
        for (int i = 0; i < 4; i++) begin
            s[i]   = x[i] + x[7-i];
            s[7-i] = x[i] - x[7-i];
        end
        e0 = s[0] + s[3]; e1 = s[1] + s[2];
        e2 = s[1] - s[2]; e3 = s[0] - s[3];
        y[0] = rnd((int'(e0) + int'(e1)) * 11585);
        y[4] = rnd((int'(e0) - int'(e1)) * 11585);
        y[2] = rnd(int'(e2) * 6270 + int'(e3) * 15137);
        y[6] = rnd(int'(e3) * 6270 - int'(e2) * 15137);
        dd = s[6] - s[5]; ss = s[6] + s[5];
        a = rnd(int'(dd) * 11585);
        b = rnd(int'(ss) * 11585);
        p0 = s[4] + a; p1 = s[4] - a; p2 = s[7] - b; p3 = s[7] + b;
        y[1] = rnd(int'(p3) * 16069 + int'(p0) * 3196);
        y[7] = rnd(int'(p3) * 3196 - int'(p0) * 16069);
        y[5] = rnd(int'(p1) * 13623 + int'(p2) * 9102);
        y[3] = rnd(int'(p2) * 13623 - int'(p1) * 9102);
        for (int k = 0; k < 8; k++) r[16*k +: 16] = y[k];
        return r;
    endfunction

    function automatic logic [127:0] pack8(int v0, int v1, int v2, int v3,
                                           int v4, int v5, int v6, int v7);
        logic [127:0] r;
        r[0 +: 16]   = v0[15:0]; r[16 +: 16]  = v1[15:0];
        r[32 +: 16]  = v2[15:0]; r[48 +: 16]  = v3[15:0];
        r[64 +: 16]  = v4[15:0]; r[80 +: 16]  = v5[15:0];
        r[96 +: 16]  = v6[15:0]; r[112 +: 16] = v7[15:0];
        return r;
    endfunction

    // ---------------- monitor: checks every cycle after reset ----------------
    always @(negedge clk) begin
        if (mon_on) begin
            if (qc.size() > 0 && qc[0] == cyc) begin
                checks++;
                if (out_valid !== 1'b1) begin
                    errors++;
                    $display("FAIL R2 out_valid got %0b exp 1 (%s)", out_valid, qt[0]);
                end
                checks++;
                if (out_coef !== qv[0]) begin
                    errors++;
                    for (int k = 0; k < 8; k++)
                        if (out_coef[16*k +: 16] !== qv[0][16*k +: 16])
                            $display("FAIL %s coef%0d got %0d exp %0d", qt[0], k,
                                     $signed(out_coef[16*k +: 16]), $signed(qv[0][16*k +: 16]));
                end
                last_out = qv[0];
                void'(qc.pop_front()); void'(qv.pop_front()); void'(qt.pop_front());
            end else begin
                checks++;
                if (out_valid !== 1'b0) begin
                    errors++;
                    $display("FAIL R2 idle out_valid got %0b exp 0", out_valid);
                end
                checks++;
                if (out_coef !== last_out) begin
                    errors++;
                    $display("FAIL R9 hold got %h exp %h", out_coef, last_out);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(logic [127:0] v, string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_samp  = v;
        qc.push_back(cyc + 3);
        qv.push_back(ref_dct(v));
        qt.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_samp  = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b1;
        in_samp = {4{32'hdeadbeef}};
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_coef !== '0) begin
            errors++;
            $display("FAIL R1 reset got valid=%0b coef=%h exp valid=0 coef=0", out_valid, out_coef);
        end
        in_valid = 1'b0;
        rst = 1'b0;
        mon_on = 1'b1;
    endtask

    task automatic t_dc();
        send(pack8(100, 100, 100, 100, 100, 100, 100, 100), "R4");
        send(pack8(-7, -7, -7, -7, -7, -7, -7, -7), "R4");
        send(pack8(0, 0, 0, 0, 0, 0, 0, 0), "R10");
        idle(4);
    endtask

    task automatic t_order();
        for (int j = 0; j < 8; j++) begin
            logic [127:0] v;
            v = '0;
            v[16*j +: 16] = 16'd1000;
            send(v, "R10");
        end
        idle(4);
    endtask

    task automatic t_wrap();
        send(pack8(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767), "R3");
        send(pack8(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768), "R3");
        send(pack8(32767, 20000, 20000, 32767, 1, -5, 20000, 32767), "R3");
        idle(3);
    endtask

    task automatic t_even_rot();
        send(pack8(0, 100, 200, 300, 400, 500, 600, 700), "R5");
        send(pack8(50, -20, -20, 50, 50, -20, -20, 50), "R5");
        send(pack8(9, 9, 9, 9, 9, 9, 9, 9), "R5");
        idle(3);
    endtask

    task automatic t_odd();
        send(pack8(0, 300, -5, 0, 0, 5, -300, 0), "R6");
        send(pack8(0, 32767, -32768, 0, 0, 32767, -32768, 0), "R6");
        send(pack8(32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768), "R7");
        send(pack8(1, -1, 1, -1, 1, -1, 1, -1), "R7");
        idle(3);
    endtask

    task automatic t_round();
        for (int v = -4; v <= 4; v++) begin
            send(pack8(v, 0, 0, 0, 0, 0, 0, 0), "R8");
            send(pack8(v, -v, 0, v, 0, 0, 0, 0), "R8");
        end
        idle(4);
    endtask

    task automatic t_hold();
        send(pack8(1234, -567, 89, -10, 11, -1213, 1415, -1617), "R9");
        idle(8);
    endtask

    task automatic t_random();
        for (int n = 0; n < 400; n++) begin
            send({$urandom, $urandom, $urandom, $urandom}, "R2");
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(5);
    endtask

    // ---------------- main ----------------
    initial begin
        t_reset();
        t_dc();
        t_order();
        t_wrap();
        t_even_rot();
        t_odd();
        t_round();
        t_hold();
        t_random();
        idle(2);
        checks++;
        if (qc.size() != 0) begin
            errors++;
            $display("FAIL R2 outstanding vectors got %0d exp 0", qc.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got running exp finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule